// File: doc/BRIEF.md
# Timer Output Waveform and Status Unit

This block is a down-counting timer. It has a preload register, a compare register, one output line whose waveform software selects, and a status word that also raises an interrupt. On each count tick the counter steps down by one. It reaches zero (a time-out) and on the next tick reloads from the preload value. A compare event happens when the counter takes the value held in the compare register. A two-bit output-mode field decides how the output line reacts to these two events: held with its driver released, toggled, forced low, or forced high. A run bit and a compare-mode bit also shape the output.

Software reaches the block through a plain synchronous register port. A write takes effect at the clock edge it is presented on. Read data is combinational from the selected register. No stream of data passes through the block, so it has no valid/ready handshake. The status word is captured into a snapshot register on every clock edge, except while a read of it is held. This keeps the read value stable for as long as the read lasts.

Register map (bus_addr): 0 control, 1 preload (a write also loads the counter), 2 compare, 3 status, 4 current count (read-only). Control bits: [0] run, [1] compare mode, [3:2] output mode (00 off, 01 toggle, 10 zero, 11 one), [4] prescaler enable, [5] time-out interrupt enable, [6] gate interrupt enable, [7] compare interrupt enable, [8] halt. Status bits: [15] interrupt, [14] time-out flag, [13] gate flag, [12] compare flag, [11] gate pin level, [10] run, [9] output level, [8] compare mode, [7:0] prescaler state (zero-extended).

Top module: `tws_timer`

## Requirements
- R1: After reset, status reads 0x0800 plus all ones in the prescaler field when gate_n is high (bit 11 follows gate_n). tout_o, tout_oe and irq_o are 0.
- R2: The counter ticks only while run=1 and halt=0. With the prescaler disabled it ticks every clock. With it enabled it ticks once every 2^PRE_W clocks, and the prescaler state sits at all ones while stopped. Each tick decrements a nonzero count; a count of zero reloads the preload value; a preload write also loads the counter.
- R3: In output mode 00, tout_oe is 0 and the output level holds. In the other modes, tout_oe is 1. Status bit 9 always shows the internal level.
- R4: Toggle mode, running: the output inverts at each time-out when compare mode=0, and at each compare event when compare mode=1.
- R5: Zero mode, running: the output goes to 0 at time-out. In compare mode it also goes to 1 at a compare event.
- R6: One mode, running: the output goes to 1 at time-out. In compare mode it also goes to 0 at a compare event.
- R7: With a compare value of 0, the time-out action wins over the compare action in zero and one modes.
- R8: With run=0, the output is held at 0 in toggle and zero modes and at 1 in one mode.
- R9: The time-out flag sets at a time-out, the compare flag sets at a compare event, and the gate flag sets when gate_n falls.
- R10: Writing 1 to status bits 14..12 clears the matching flags, and writing 0 has no effect. A set event in the same cycle wins over the clear. Clearing writes are ignored while halt=1.
- R11: irq_o and status bit 15 are the OR of the three flags, each gated by its enable.
- R12: While a read of the status address is held across clock edges, the status value does not change. Otherwise the status register captures the live state on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read in progress |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| gate_n | input | 1 | Active-low gate input, already synchronous |
| tout_o | output | 1 | Timer output level |
| tout_oe | output | 1 | Output driver enable; 0 means high impedance |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W=16 and PRE_W=4. With that prescaler width, a prescaled tick arrives every 16 clocks, so the divided count rate is checked within a few dozen cycles. Preload values of 3 and 5 put time-outs and compare events a handful of cycles apart. This lets every output mode be checked in both plain and compare operation, including the compare-value-zero tie. It also allows a clearing write to be placed exactly on a time-out edge, and a held status read to span one.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_ZERO   = 2'b10,
    OM_ONE    = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic      halt;
    logic      ie_tc;
    logic      ie_tg;
    logic      ie_to;
    logic      presc_en;
    out_mode_e mode;
    logic      cmp_mode;
    logic      run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int BUS_W  = 16;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRE  = 3'd1;
  localparam logic [2:0] A_CMP  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  // flag vector order used across the block: [2] time-out, [1] gate, [0] compare
  localparam int FL_TO = 2;
  localparam int FL_TG = 1;
  localparam int FL_TC = 0;
endpackage

// File: rtl/tws_prescaler.sv
module tws_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bypass,
  output logic             tick,
  output logic [PRE_W-1:0] state
);
  localparam logic [PRE_W-1:0] P_ONES = '1;
  localparam logic [PRE_W-1:0] P_ONE  = PRE_W'(1);

  logic [PRE_W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= P_ONES;
    else if (!enable) st_q <= P_ONES;
    else              st_q <= st_q - P_ONE;
  end

  assign tick  = enable && (bypass || (st_q == '0));
  assign state = st_q;

  // R2: a stopped prescaler returns to all ones
  assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == P_ONES));
endmodule

// File: rtl/tws_counter.sv
module tws_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] count,
  output logic             to_ev,
  output logic             cmp_ev
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == '0) cnt_nxt = preload;
    else             cnt_nxt = cnt_q - C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_nxt;
  end

  assign to_ev  = tick && !load && (cnt_nxt == '0);
  assign cmp_ev = tick && !load && (cnt_nxt == compare);
  assign count  = cnt_q;

  // R2: a tick at zero brings back the preload value
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q == '0) |=> (cnt_q == $past(preload)));
  // R2: a tick on a nonzero count steps down by one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - C_ONE));
endmodule

// File: rtl/tws_outctl.sv
module tws_outctl
  import tws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      cmp_mode,
  input  out_mode_e mode,
  input  logic      to_ev,
  input  logic      cmp_ev,
  output logic      level,
  output logic      oe
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!run) begin
      unique case (mode)
        OM_TOGGLE, OM_ZERO: lvl_d = 1'b0;
        OM_ONE:             lvl_d = 1'b1;
        default:            lvl_d = lvl_q;
      endcase
    end else if (cmp_mode) begin
      unique case (mode)
        OM_TOGGLE: if (cmp_ev) lvl_d = ~lvl_q;
        OM_ZERO: begin
          if (to_ev)       lvl_d = 1'b0;
          else if (cmp_ev) lvl_d = 1'b1;
        end
        OM_ONE: begin
          if (to_ev)       lvl_d = 1'b1;
          else if (cmp_ev) lvl_d = 1'b0;
        end
        default: lvl_d = lvl_q;
      endcase
    end else begin
      unique case (mode)
        OM_TOGGLE: if (to_ev) lvl_d = ~lvl_q;
        OM_ZERO:   if (to_ev) lvl_d = 1'b0;
        OM_ONE:    if (to_ev) lvl_d = 1'b1;
        default:   lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
  assign oe    = (mode != OM_OFF);

  // R8: stopped in one mode drives high
  assert_stop_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && mode == OM_ONE) |=> lvl_q);
  // R8: stopped in zero mode drives low
  assert_stop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && mode == OM_ZERO) |=> !lvl_q);
  // R7: coincident events in zero mode end low
  assert_tie_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_mode && mode == OM_ZERO && to_ev && cmp_ev) |=> !lvl_q);
  // R3: off mode never changes the level
  assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_OFF) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/tws_status.sv
module tws_status
  import tws_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             to_ev,
  input  logic             cmp_ev,
  input  logic             gate_n,
  input  logic             clr_en,
  input  logic [2:0]       clr_mask,
  input  logic [2:0]       irq_en,
  input  logic             freeze,
  input  logic             run,
  input  logic             level,
  input  logic             cmp_mode,
  input  logic [PRE_W-1:0] presc,
  output logic [BUS_W-1:0] snap,
  output logic             irq
);
  localparam logic [7:0] P_RST = 8'({PRE_W{1'b1}});

  logic [2:0]       flags_q;
  logic [2:0]       set_v;
  logic [2:0]       clr_v;
  logic             gate_q;
  logic             irq_live;
  logic [BUS_W-1:0] snap_q;
  logic [BUS_W-1:0] snap_d;

  assign set_v[FL_TO] = to_ev;
  assign set_v[FL_TG] = gate_q && !gate_n;
  assign set_v[FL_TC] = cmp_ev;
  assign clr_v        = clr_en ? clr_mask : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 3'b000;
      gate_q  <= gate_n;
    end else begin
      flags_q <= (flags_q & ~clr_v) | set_v;
      gate_q  <= gate_n;
    end
  end

  assign irq_live = |(flags_q & irq_en);

  assign snap_d = {irq_live, flags_q[FL_TO], flags_q[FL_TG], flags_q[FL_TC],
                   gate_n, run, level, cmp_mode, 8'(presc)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= {4'b0000, gate_n, 3'b000, P_RST};
    else if (!freeze) snap_q <= snap_d;
  end

  assign snap = snap_q;
  assign irq  = irq_live;

  // R12: a held status read keeps its value
  assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (snap_q == $past(snap_q)));
  // R10: a time-out event wins over a same-cycle clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    to_ev |=> flags_q[FL_TO]);
  // R10: an accepted clear without a new event empties the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[FL_TO] && !to_ev) |=> !flags_q[FL_TO]);
  // R11: with no flag pending there is no request
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == 3'b000) |-> !irq);
endmodule

// File: rtl/tws_timer.sv
module tws_timer
  import tws_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             gate_n,
  output logic             tout_o,
  output logic             tout_oe,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_ONES = '1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cmp_q;
  logic             wr_ctrl, wr_pre, wr_cmp, wr_stat, rd_stat;
  logic             active, tick, to_ev, cmp_ev, level;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] snap;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_pre  = bus_wr && (bus_addr == A_PRE);
  assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= CNT_ONES;
      cmp_q  <= CNT_ONES;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_pre)  pre_q  <= bus_wdata[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  assign active = ctrl_q.run && !ctrl_q.halt;

  tws_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (active),
    .bypass (!ctrl_q.presc_en),
    .tick   (tick),
    .state  (presc)
  );

  tws_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_pre),
    .load_val (bus_wdata[CNT_W-1:0]),
    .preload  (pre_q),
    .compare  (cmp_q),
    .count    (count),
    .to_ev    (to_ev),
    .cmp_ev   (cmp_ev)
  );

  tws_outctl u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .cmp_mode (ctrl_q.cmp_mode),
    .mode     (ctrl_q.mode),
    .to_ev    (to_ev),
    .cmp_ev   (cmp_ev),
    .level    (level),
    .oe       (tout_oe)
  );

  tws_status #(.PRE_W(PRE_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .to_ev    (to_ev),
    .cmp_ev   (cmp_ev),
    .gate_n   (gate_n),
    .clr_en   (wr_stat && !ctrl_q.halt),
    .clr_mask (bus_wdata[14:12]),
    .irq_en   ({ctrl_q.ie_to, ctrl_q.ie_tg, ctrl_q.ie_tc}),
    .freeze   (rd_stat),
    .run      (ctrl_q.run),
    .level    (level),
    .cmp_mode (ctrl_q.cmp_mode),
    .presc    (presc),
    .snap     (snap),
    .irq      (irq_o)
  );

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = BUS_W'(ctrl_q);
      A_PRE:   bus_rdata = BUS_W'(pre_q);
      A_CMP:   bus_rdata = BUS_W'(cmp_q);
      A_STAT:  bus_rdata = snap;
      A_CNT:   bus_rdata = BUS_W'(count);
      default: bus_rdata = '0;
    endcase
  end

  assign tout_o = level;

  // R2: halt stops the counter
  assert_halt_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.halt && !wr_pre) |=> (count == $past(count)));
endmodule

// File: tb/tws_timer_tb.sv
module tws_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        gate_n = 1'b1;
  logic        tout_o, tout_oe, irq_o;
  int          nchk = 0, nerr = 0;

  localparam logic [2:0] AC = 3'd0, AP = 3'd1, AM = 3'd2, AS = 3'd3, AN = 3'd4;
  localparam logic [1:0] M_OFF = 2'b00, M_TOG = 2'b01, M_ZER = 2'b10, M_ONE = 2'b11;

  tws_timer #(.CNT_W(16), .PRE_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_n(gate_n),
    .tout_o(tout_o), .tout_oe(tout_oe), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // ie = {tc, tg, to}
  function automatic logic [15:0] cw(bit run, bit cmp, logic [1:0] mode, bit pen,
                                     logic [2:0] ie, bit halt);
    return {7'b0, halt, ie, pen, mode, cmp, run};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [15:0] stop_cw, logic [15:0] pre, logic [15:0] cmp);
    wr(AC, stop_cw);
    wr(AP, pre);
    wr(AM, cmp);
    wr(AS, 16'h7000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(AS, d);
    chk("R1 status", d, 16'h080F);
    chk("R1 tout", {15'b0, tout_o}, 16'h0);
    chk("R1 oe", {15'b0, tout_oe}, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    setup(cw(0, 0, M_TOG, 1, 3'b000, 0), 16'd3, 16'hFFFF);
    peek(AN, d); chk("R2 preload loads count", d, 16'd3);
    wr(AC, cw(1, 0, M_TOG, 1, 3'b000, 0));
    step(15); peek(AN, d); chk("R2 prescaled hold", d, 16'd3);
    step(1);  peek(AN, d); chk("R2 prescaled tick", d, 16'd2);
    step(16); peek(AN, d); chk("R2 prescaled period", d, 16'd1);
    setup(cw(0, 0, M_TOG, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 0));
    step(1); peek(AN, d); chk("R2 decrement", d, 16'd2);
    step(2); peek(AN, d); chk("R2 zero", d, 16'd0);
    step(1); peek(AN, d); chk("R2 reload", d, 16'd3);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 1));
    step(3); peek(AN, d);
    begin
      logic [15:0] e;
      step(4); peek(AN, e); chk("R2 halt holds count", e, d);
    end
  endtask

  task automatic t_toggle();
    logic [15:0] d;
    setup(cw(0, 0, M_TOG, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    chk("R8 toggle stopped low", {15'b0, tout_o}, 16'h0);
    chk("R3 oe on", {15'b0, tout_oe}, 16'h1);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 0));
    step(2); chk("R4 before time-out", {15'b0, tout_o}, 16'h0);
    step(1); chk("R4 toggle at time-out", {15'b0, tout_o}, 16'h1);
    step(1); peek(AS, d); chk("R9 time-out flag status", d & 16'hFF00, 16'h4E00);
    step(3); chk("R4 toggle back", {15'b0, tout_o}, 16'h0);
    setup(cw(0, 1, M_TOG, 0, 3'b000, 0), 16'd5, 16'd2);
    wr(AC, cw(1, 1, M_TOG, 0, 3'b000, 0));
    step(2); chk("R4 cmp before", {15'b0, tout_o}, 16'h0);
    step(1); chk("R4 cmp toggle", {15'b0, tout_o}, 16'h1);
    step(1); peek(AS, d); chk("R9 compare flag", d & 16'h1000, 16'h1000);
    step(1); chk("R4 time-out ignored in cmp mode", {15'b0, tout_o}, 16'h1);
    step(4); chk("R4 cmp toggle back", {15'b0, tout_o}, 16'h0);
  endtask

  task automatic t_zero_one();
    setup(cw(0, 0, M_ONE, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    chk("R8 one stopped high", {15'b0, tout_o}, 16'h1);
    wr(AC, cw(1, 0, M_ZER, 0, 3'b000, 0));
    step(2); chk("R5 holds before time-out", {15'b0, tout_o}, 16'h1);
    step(1); chk("R5 low at time-out", {15'b0, tout_o}, 16'h0);
    setup(cw(0, 1, M_ZER, 0, 3'b000, 0), 16'd5, 16'd2);
    chk("R8 zero stopped low", {15'b0, tout_o}, 16'h0);
    wr(AC, cw(1, 1, M_ZER, 0, 3'b000, 0));
    step(3); chk("R5 high at compare", {15'b0, tout_o}, 16'h1);
    step(1); chk("R5 hold", {15'b0, tout_o}, 16'h1);
    step(1); chk("R5 low at time-out cmp", {15'b0, tout_o}, 16'h0);
    setup(cw(0, 0, M_ZER, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(1, 0, M_ONE, 0, 3'b000, 0));
    step(2); chk("R6 holds before time-out", {15'b0, tout_o}, 16'h0);
    step(1); chk("R6 high at time-out", {15'b0, tout_o}, 16'h1);
    setup(cw(0, 1, M_ONE, 0, 3'b000, 0), 16'd5, 16'd2);
    wr(AC, cw(1, 1, M_ONE, 0, 3'b000, 0));
    step(3); chk("R6 low at compare", {15'b0, tout_o}, 16'h0);
    step(2); chk("R6 high at time-out cmp", {15'b0, tout_o}, 16'h1);
  endtask

  task automatic t_tie();
    setup(cw(0, 1, M_ZER, 0, 3'b000, 0), 16'd3, 16'd0);
    wr(AC, cw(1, 1, M_ZER, 0, 3'b000, 0));
    step(3); chk("R7 zero mode tie low", {15'b0, tout_o}, 16'h0);
    step(1); chk("R7 zero mode stays low", {15'b0, tout_o}, 16'h0);
    setup(cw(0, 1, M_ONE, 0, 3'b000, 0), 16'd3, 16'd0);
    wr(AC, cw(1, 1, M_ONE, 0, 3'b000, 0));
    step(3); chk("R7 one mode tie high", {15'b0, tout_o}, 16'h1);
  endtask

  task automatic t_off();
    logic [15:0] d;
    setup(cw(0, 0, M_ONE, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(0, 0, M_OFF, 0, 3'b000, 0));
    wr(AC, cw(1, 0, M_OFF, 0, 3'b000, 0));
    step(4);
    chk("R3 oe off", {15'b0, tout_oe}, 16'h0);
    chk("R3 level held", {15'b0, tout_o}, 16'h1);
    peek(AS, d); chk("R3 status shows level", d & 16'h0200, 16'h0200);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    setup(cw(0, 0, M_TOG, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 0));
    step(3); chk("R11 disabled flag no irq", {15'b0, irq_o}, 16'h0);
    wr(AC, cw(0, 0, M_TOG, 0, 3'b001, 0));
    chk("R11 enabled flag irq", {15'b0, irq_o}, 16'h1);
    step(1); peek(AS, d); chk("R11 status irq bit", d & 16'hC000, 16'hC000);
    wr(AS, 16'h0000); chk("R10 write zero no effect", {15'b0, irq_o}, 16'h1);
    wr(AC, cw(0, 0, M_TOG, 0, 3'b001, 1));
    wr(AS, 16'h4000); chk("R10 clear ignored in halt", {15'b0, irq_o}, 16'h1);
    wr(AC, cw(0, 0, M_TOG, 0, 3'b001, 0));
    wr(AS, 16'h4000); chk("R10 clear", {15'b0, irq_o}, 16'h0);
    setup(cw(0, 0, M_TOG, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 0));
    step(1);
    wr(AS, 16'h4000);
    step(1); peek(AS, d); chk("R10 set wins", d & 16'h4000, 16'h4000);
    wr(AC, cw(0, 0, M_TOG, 0, 3'b010, 0));
    wr(AS, 16'h7000);
    gate_n = 1'b0;
    step(2); peek(AS, d); chk("R9 gate flag and level", d & 16'h2800, 16'h2000);
    chk("R11 gate irq", {15'b0, irq_o}, 16'h1);
    gate_n = 1'b1;
    step(2); peek(AS, d); chk("R9 gate level high", d & 16'h0800, 16'h0800);
  endtask

  task automatic t_freeze();
    logic [15:0] a, b, c;
    setup(cw(0, 0, M_TOG, 0, 3'b000, 0), 16'd3, 16'hFFFF);
    wr(AC, cw(1, 0, M_TOG, 0, 3'b000, 0));
    bus_rd = 1'b1; bus_addr = AS;
    #1 a = bus_rdata;
    step(5);
    #1 b = bus_rdata;
    bus_rd = 1'b0;
    chk("R12 frozen before", a & 16'h4000, 16'h0000);
    chk("R12 frozen across time-out", b, a);
    step(1); peek(AS, c); chk("R12 updates after read", c & 16'h4000, 16'h4000);
  endtask

  initial begin
    #2_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_count();
    t_toggle();
    t_zero_one();
    t_tie();
    t_off();
    t_flags();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule